// File: doc/BRIEF.md
# Microcode Opcode Dispatch Unit

This block turns an incoming opcode into control-row activity. It reads a 32-bit descriptor for the opcode from a 256-entry table. It then splits that descriptor into two row indices: one into a table of 64-bit fast control words and one into a table of 112-bit slow control words.

Every op issues exactly one fast word to the datapath as a single step. When the slow index is nonzero, that fast step acts as a setup step. After it, the block starts an external slow-program sequencer, passing it the slow row index and the slow word. The block then waits for the sequencer's done pulse. When the slow index is zero, the op completes right after the fast step.

All three tables are RAMs, written through one load port while the block is idle. Rows may be shared by several opcodes. Datapath execution and the walk of the slow program happen outside this block.

Top module: `uop_dispatch`

## Requirements
- R1: After reset, op_ready is 1 and issue_valid, slow_start and op_done are 0.
- R2: An accepted opcode (op_valid and op_ready high at a clock edge) reads the descriptor at that opcode's address. The fast row index is descriptor bits [7:0]. issue_valid is high for exactly one cycle, two cycles after the accepting edge. In that cycle issue_word carries the 64-bit fast row.
- R3: When descriptor bits [15:8] are zero, the op is fast-only. It makes one issue pulse, no slow_start, and op_done is high for one cycle, in the cycle after the issue pulse.
- R4: When descriptor bits [15:8] are nonzero, slow_start is high for one cycle, in the cycle right after the issue pulse and never before it. During that cycle slow_row equals bits [15:8] and slow_word carries the 112-bit slow row at that index.
- R5: After slow_start, the block waits for slow_done. op_done is high for one cycle, one cycle after slow_done is sampled. A slow_done seen in the same cycle as slow_start is ignored.
- R6: op_ready is low from the accepting edge until the cycle after op_done. While op_ready is low, op_valid has no effect.
- R7: Load port: ld_sel 0 writes the opcode table (ld_data[31:0]), 1 writes the fast table (ld_data[63:0]) and 2 writes the slow table (ld_data[111:0]), each at ld_addr. ld_sel 3 writes nothing.
- R8: Descriptor bits [31:16] have no effect on the dispatch.
- R9: Different opcodes whose descriptors name the same fast or slow row get the same control words.
- R10: Writes on the load port take effect only while the block is idle; writes during an op are dropped. op_ready is low while ld_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode offered |
| op_opcode | input | 8 | Opcode value |
| op_ready | output | 1 | Block can accept an opcode |
| issue_valid | output | 1 | One-cycle fast-step issue strobe |
| issue_word | output | 64 | Fast control word |
| slow_start | output | 1 | One-cycle slow program start strobe |
| slow_row | output | 8 | Slow row index for the sequencer |
| slow_word | output | 112 | Slow control word for the sequencer |
| slow_done | input | 1 | Sequencer finished |
| op_done | output | 1 | One-cycle op completion strobe |
| ld_en | input | 1 | Table write enable |
| ld_sel | input | 2 | Table select (0 opcode, 1 fast, 2 slow) |
| ld_addr | input | 8 | Table row address |
| ld_data | input | 128 | Row data, low bits used per table |

## Verification
The assertions check, on every cycle, the things that hold no matter what the tables contain:
- the issue, start and completion strobes each last one cycle and never overlap;
- a slow start is always preceded by a fast issue and always carries a nonzero row;
- an accepted opcode drops op_ready on the next cycle.

Only the directed scenarios can show that the right words come out. They cover:
- that descriptor bits are split correctly, including the boundary rows 0 and 255;
- that ignored descriptor bits really have no effect;
- that shared rows return the same words;
- that an early slow_done and load writes during an op leave the behaviour unchanged, which the bench sees later through the issued words.

// File: rtl/dsp_pkg.sv
// Package: shared sizes, table select codes and the dispatch state type.
// Assumes one opcode in flight; all tables are single-port-write, sync-read.
package dsp_pkg;
    localparam int OPC_W  = 8;    // opcode width, table depth 2**OPC_W
    localparam int ROW_W  = 8;    // control row index width
    localparam int DESC_W = 32;   // descriptor width
    localparam int FAST_W = 64;   // fast control word width
    localparam int SLOW_W = 112;  // slow control word width
    localparam int SLOT_W = 128;  // load data width (one 16-byte slot)

    localparam int NTAB   = 3;    // number of writable tables
    localparam int SEL_W  = 2;    // table select width

    localparam int TSEL_OPC  = 0;
    localparam int TSEL_FAST = 1;
    localparam int TSEL_SLOW = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_ISSUE,
        ST_START,
        ST_WAIT,
        ST_DONE
    } dsp_state_e;
endpackage

// File: rtl/dsp_table_ram.sv
// Module: dsp_table_ram
// Generic table RAM with one synchronous write port and one registered
// read port. rdata holds its value when no read is requested.
// Assumes a write and a read to the same row in the same cycle need not
// forward the new data.
module dsp_table_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a row on a write request.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the addressed row on a read request, hold otherwise.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dsp_load_dec.sv
// Module: dsp_load_dec
// Turns the load port's table select into one write enable per table.
// Assumes writes are allowed only while the dispatcher is idle; 'allow'
// carries that condition. Select codes with no table produce no enable.
module dsp_load_dec #(
    parameter int NTAB  = dsp_pkg::NTAB,
    parameter int SEL_W = dsp_pkg::SEL_W
) (
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic             allow,
    output logic [NTAB-1:0]  we
);
    for (genvar i = 0; i < NTAB; i++) begin : g_we
        // One enable per table when its code is selected.
        assign we[i] = ld_en && allow && (ld_sel == SEL_W'(i));
    end
endmodule

// File: rtl/dsp_ctrl.sv
// Module: dsp_ctrl
// Dispatch sequencer:
//   accept opcode -> read descriptor -> read both control rows ->
//   issue fast step -> (if slow index nonzero) start slow program and wait
//   -> signal completion.
// Assumes the table RAMs have one cycle of read latency and that their
// outputs hold while no read is requested.
module dsp_ctrl
    import dsp_pkg::*;
#(
    parameter int ROW_W_P  = ROW_W,
    parameter int DESC_W_P = DESC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic                ld_en,
    input  logic [DESC_W_P-1:0] desc,
    input  logic                slow_done,
    output logic                op_ready,
    output logic                idle,
    output logic                opc_re,
    output logic                row_re,
    output logic [ROW_W_P-1:0]  fast_idx,
    output logic [ROW_W_P-1:0]  slow_idx_rd,
    output logic [ROW_W_P-1:0]  slow_row,
    output logic                issue_valid,
    output logic                slow_start,
    output logic                op_done
);
    dsp_state_e         state_q, state_d;
    logic [ROW_W_P-1:0] slow_idx_q;
    logic               unused_desc_hi;

    assign idle           = (state_q == ST_IDLE);
    assign op_ready       = idle && !ld_en;
    assign opc_re         = op_valid && op_ready;
    assign row_re         = (state_q == ST_DESC);
    assign fast_idx       = desc[ROW_W_P-1:0];
    assign slow_idx_rd    = desc[2*ROW_W_P-1:ROW_W_P];
    assign unused_desc_hi = ^desc[DESC_W_P-1:2*ROW_W_P];
    assign issue_valid    = (state_q == ST_ISSUE);
    assign slow_start     = (state_q == ST_START);
    assign op_done        = (state_q == ST_DONE);
    assign slow_row       = slow_idx_q;

    // Next-state choice for the dispatch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (opc_re) state_d = ST_DESC;
            ST_DESC:  state_d = ST_ISSUE;
            ST_ISSUE: state_d = (slow_idx_q != '0) ? ST_START : ST_DONE;
            ST_START: state_d = ST_WAIT;
            ST_WAIT:  if (slow_done) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the slow row index once the descriptor is on the RAM output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_idx_q <= '0;
        end else if (state_q == ST_DESC) begin
            slow_idx_q <= slow_idx_rd;
        end
    end

    // A slow start is only ever issued for a nonzero slow row (R4).
    assert_start_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_start |-> (slow_row != '0));

    // The setup step comes in the cycle right before the slow start (R4).
    assert_setup_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_start |-> $past(issue_valid));

    // Completion follows either a fast-only issue or a sampled done (R3, R5).
    assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> ($past(issue_valid) || $past(slow_done)));
endmodule

// File: rtl/uop_dispatch.sv
// Module: uop_dispatch (top)
// Opcode dispatch unit. It holds three tables:
//   - opcode -> 32-bit descriptor,
//   - fast control words, 64 bits,
//   - slow control words, 112 bits.
// It issues the fast word as one step and, for a nonzero slow index, hands
// that index and slow word to an external sequencer, then waits for done.
// Assumes the load port is driven only between ops; writes during an op
// are dropped.
module uop_dispatch
    import dsp_pkg::*;
#(
    parameter int OPC_WP  = OPC_W,
    parameter int ROW_WP  = ROW_W,
    parameter int DESC_WP = DESC_W,
    parameter int FAST_WP = FAST_W,
    parameter int SLOW_WP = SLOW_W,
    parameter int SLOT_WP = SLOT_W,
    localparam int ADDR_W = (OPC_WP > ROW_WP) ? OPC_WP : ROW_WP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [OPC_WP-1:0]  op_opcode,
    output logic               op_ready,
    output logic               issue_valid,
    output logic [FAST_WP-1:0] issue_word,
    output logic               slow_start,
    output logic [ROW_WP-1:0]  slow_row,
    output logic [SLOW_WP-1:0] slow_word,
    input  logic               slow_done,
    output logic               op_done,
    input  logic               ld_en,
    input  logic [SEL_W-1:0]   ld_sel,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [SLOT_WP-1:0] ld_data
);
    logic [NTAB-1:0]    tab_we;
    logic               idle;
    logic               opc_re;
    logic               row_re;
    logic [DESC_WP-1:0] desc;
    logic [ROW_WP-1:0]  fast_idx;
    logic [ROW_WP-1:0]  slow_idx_rd;
    logic               unused_ld_hi;

    assign unused_ld_hi = ^ld_data[SLOT_WP-1:SLOW_WP];

    dsp_load_dec #(.NTAB(NTAB), .SEL_W(SEL_W)) u_load_dec (
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .allow  (idle),
        .we     (tab_we)
    );

    dsp_table_ram #(.WIDTH(DESC_WP), .DEPTH(1 << OPC_WP)) u_opc_ram (
        .clk   (clk),
        .we    (tab_we[TSEL_OPC]),
        .waddr (ld_addr[OPC_WP-1:0]),
        .wdata (ld_data[DESC_WP-1:0]),
        .re    (opc_re),
        .raddr (op_opcode),
        .rdata (desc)
    );

    dsp_table_ram #(.WIDTH(FAST_WP), .DEPTH(1 << ROW_WP)) u_fast_ram (
        .clk   (clk),
        .we    (tab_we[TSEL_FAST]),
        .waddr (ld_addr[ROW_WP-1:0]),
        .wdata (ld_data[FAST_WP-1:0]),
        .re    (row_re),
        .raddr (fast_idx),
        .rdata (issue_word)
    );

    dsp_table_ram #(.WIDTH(SLOW_WP), .DEPTH(1 << ROW_WP)) u_slow_ram (
        .clk   (clk),
        .we    (tab_we[TSEL_SLOW]),
        .waddr (ld_addr[ROW_WP-1:0]),
        .wdata (ld_data[SLOW_WP-1:0]),
        .re    (row_re),
        .raddr (slow_idx_rd),
        .rdata (slow_word)
    );

    dsp_ctrl #(.ROW_W_P(ROW_WP), .DESC_W_P(DESC_WP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .ld_en       (ld_en),
        .desc        (desc),
        .slow_done   (slow_done),
        .op_ready    (op_ready),
        .idle        (idle),
        .opc_re      (opc_re),
        .row_re      (row_re),
        .fast_idx    (fast_idx),
        .slow_idx_rd (slow_idx_rd),
        .slow_row    (slow_row),
        .issue_valid (issue_valid),
        .slow_start  (slow_start),
        .op_done     (op_done)
    );

    // The issue strobe lasts one cycle (R2).
    assert_issue_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    // The slow start strobe lasts one cycle (R4).
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_start |=> !slow_start);

    // The output strobes never overlap (R3).
    assert_strobes_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_valid, slow_start, op_done}));

    // An accepted opcode closes the door on the next cycle (R6).
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    // No load is possible while ready is shown (R10).
    assert_ready_vs_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !op_ready);
endmodule

// File: tb/uop_dispatch_bench.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
// Inputs change on the falling edge; outputs are sampled there too.
module uop_dispatch_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [7:0]   op_opcode = '0;
    logic         op_ready;
    logic         issue_valid;
    logic [63:0]  issue_word;
    logic         slow_start;
    logic [7:0]   slow_row;
    logic [111:0] slow_word;
    logic         slow_done = 1'b0;
    logic         op_done;
    logic         ld_en = 1'b0;
    logic [1:0]   ld_sel = '0;
    logic [7:0]   ld_addr = '0;
    logic [127:0] ld_data = '0;

    int checks = 0;
    int errors = 0;

    // Expected words, chosen by the bench.
    localparam logic [63:0]  F0   = 64'h0000_0001_2080_0900;
    localparam logic [63:0]  F5   = 64'hA5A5_0102_A089_0C00;
    localparam logic [63:0]  F7   = 64'h0000_E800_A082_0800;
    localparam logic [63:0]  F255 = 64'h1234_5678_9ABC_DEF0;
    localparam logic [111:0] S3   = 112'h0102_0304_0506_0001_30C3_0CC3_0000;
    localparam logic [111:0] S255 = 112'hFFEE_DDCC_BBAA_0007_30C3_0CC1_0C00;

    always #2 clk = ~clk;

    uop_dispatch u_uop_dispatch (
        .clk, .rst_n, .op_valid, .op_opcode, .op_ready, .issue_valid,
        .issue_word, .slow_start, .slow_row, .slow_word, .slow_done,
        .op_done, .ld_en, .ld_sel, .ld_addr, .ld_data
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] sel, input logic [7:0] addr,
                        input logic [127:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = addr; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0; ld_data = '0;
    endtask

    // Run one op. For slow ops: optional early done during the start cycle,
    // optional write and op offer while busy, then done after 'dly' cycles.
    task automatic run_op(input logic [7:0] opc, input logic [63:0] ew,
                          input logic [7:0] es, input logic [111:0] esw,
                          input int dly, input bit early_done,
                          input bit busy_poke, input string tag);
        @(negedge clk);
        chk(op_ready == 1'b1, {tag, " R6 ready before"}, 128'(op_ready), 128'd1);
        op_valid = 1'b1; op_opcode = opc;
        @(negedge clk);                       // accepted at the edge before
        op_valid = 1'b0;
        chk(op_ready == 1'b0, {tag, " R6 busy"}, 128'(op_ready), 128'd0);
        chk(issue_valid == 1'b0, {tag, " R2 no early issue"}, 128'(issue_valid), 128'd0);
        @(negedge clk);
        chk(issue_valid == 1'b1, {tag, " R2 issue pulse"}, 128'(issue_valid), 128'd1);
        chk(issue_word == ew, {tag, " R2 issue word"}, 128'(issue_word), 128'(ew));
        chk(slow_start == 1'b0, {tag, " R4 start after issue"}, 128'(slow_start), 128'd0);
        @(negedge clk);
        chk(issue_valid == 1'b0, {tag, " R2 one cycle"}, 128'(issue_valid), 128'd0);
        if (es == 8'd0) begin
            chk(slow_start == 1'b0, {tag, " R3 no slow start"}, 128'(slow_start), 128'd0);
            chk(op_done == 1'b1, {tag, " R3 done"}, 128'(op_done), 128'd1);
        end else begin
            chk(slow_start == 1'b1, {tag, " R4 start"}, 128'(slow_start), 128'd1);
            chk(slow_row == es, {tag, " R4 slow row"}, 128'(slow_row), 128'(es));
            chk(slow_word == esw, {tag, " R4 slow word"}, 128'(slow_word), 128'(esw));
            chk(op_done == 1'b0, {tag, " R5 not done"}, 128'(op_done), 128'd0);
            if (early_done) slow_done = 1'b1;
            @(negedge clk);
            slow_done = 1'b0;
            chk(slow_start == 1'b0, {tag, " R4 start one cycle"}, 128'(slow_start), 128'd0);
            if (busy_poke) begin
                ld_en = 1'b1; ld_sel = 2'd1; ld_addr = 8'd5; ld_data = '1;
                op_valid = 1'b1; op_opcode = 8'h10;
            end
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk(op_done == 1'b0, {tag, " R5 waiting"}, 128'(op_done), 128'd0);
                chk(issue_valid == 1'b0, {tag, " R6 offer ignored"}, 128'(issue_valid), 128'd0);
            end
            ld_en = 1'b0; ld_data = '0; op_valid = 1'b0;
            slow_done = 1'b1;
            @(negedge clk);
            slow_done = 1'b0;
            chk(op_done == 1'b1, {tag, " R5 done after slow_done"}, 128'(op_done), 128'd1);
        end
        @(negedge clk);
        chk(op_done == 1'b0, {tag, " R5 done one cycle"}, 128'(op_done), 128'd0);
        chk(op_ready == 1'b1, {tag, " R6 ready again"}, 128'(op_ready), 128'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(op_ready == 1'b1, "R1 ready", 128'(op_ready), 128'd1);
        chk(issue_valid == 1'b0, "R1 issue", 128'(issue_valid), 128'd0);
        chk(slow_start == 1'b0, "R1 start", 128'(slow_start), 128'd0);
        chk(op_done == 1'b0, "R1 done", 128'(op_done), 128'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_load_tables();
        load(2'd0, 8'h10, {96'hFFFF, 32'h0000_0005});   // fast 5, slow 0
        load(2'd0, 8'h20, 128'h0000_0307);              // fast 7, slow 3
        load(2'd0, 8'h21, 128'hFFFF_0305);              // R8 high bits set
        load(2'd0, 8'hFF, 128'h0000_FF00);              // fast 0, slow 255
        load(2'd0, 8'h00, 128'hABCD_00FF);              // fast 255, slow 0
        load(2'd1, 8'd0,  {64'hDEAD, F0});
        load(2'd1, 8'd5,  {64'hBEEF, F5});
        load(2'd1, 8'd7,  128'(F7));
        load(2'd1, 8'd255, 128'(F255));
        load(2'd2, 8'd3,  {16'hCAFE, S3});
        load(2'd2, 8'd255, 128'(S255));
        // R7: select code 3 must not disturb fast row 5.
        load(2'd3, 8'd5, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        // R10: ready is low while a load is offered.
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd3;
        #1;
        chk(op_ready == 1'b0, "R10 ready low during load", 128'(op_ready), 128'd0);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_tables();
                run_op(8'h10, F5, 8'd0, '0, 0, 1'b0, 1'b0, "R3 fast-only R7 sel3");
                run_op(8'h20, F7, 8'd3, S3, 2, 1'b0, 1'b0, "R4 slow");
                run_op(8'h21, F5, 8'd3, S3, 0, 1'b0, 1'b0, "R8 R9 shared rows");
                run_op(8'hFF, F0, 8'd255, S255, 4, 1'b1, 1'b0, "R5 early done row255");
                run_op(8'h00, F255, 8'd0, '0, 0, 1'b0, 1'b0, "R8 fast row255");
                run_op(8'h20, F7, 8'd3, S3, 3, 1'b0, 1'b1, "R10 busy write");
                run_op(8'h10, F5, 8'd0, '0, 0, 1'b0, 1'b0, "R10 row5 intact");
            end
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired actual=hung expected=finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule